// File: doc/BRIEF.md
# Single-Channel PWM Generator with Staged, Lockable Updates

This block produces one pulse-width-modulated output from a free-running counter. Software programs it through a plain write/read register port with four word registers: a read-only live count, a period, a duty length and a control word. Period and duty are counted in cycles of the block clock, with a prescale of one.

Period, duty and the two output levels are written into staging copies. The running waveform uses separate active copies. The staged values move into the active copies only at a period boundary. While the channel is idle they move on every cycle. A lock bit in the control word blocks that move. Software sets the lock, rewrites period and duty at leisure, and then clears the lock in the same control write that sets the new polarity. The three changes then start together at the beginning of the next period, and no period mixes old and new settings.

Top module: `pwm_lockshadow`

## Requirements
- R1: After reset every register reads zero and the output is low.
- R2: Byte offset 0x4 holds the period and 0x8 holds the duty. Each reads back the value last written, even while that value is not yet active. Offset 0xC holds the control word, where only bits 0, 1, 3, 4, 5, 6 and 8 are stored (mask 0x17B) and all other bits read zero. Unmapped offsets read zero.
- R3: Offset 0x0 returns the live count, and writes to it have no effect.
- R4: The channel runs only when control bit 0 (enable) is 1, bit 1 (continuous) is 1, bit 5 (alignment, 0 = left) is 0 and bit 8 (low power) is 0.
- R5: While the channel is not running, the count stays at 0 and the output sits at the active inactive-phase level.
- R6: While running, the count steps by one per clock from 0 to period-1 and then returns to 0. A period of 0 or 1 keeps the count at 0.
- R7: While running, the output shows the duty-phase level when count < duty and the inactive-phase level otherwise.
- R8: A duty of 0 gives a constant inactive-phase level. A duty of at least the period gives a constant duty-phase level.
- R9: Control bit 3 is the duty-phase level and bit 4 is the inactive-phase level. Normal polarity is 0x08 in these bits and inverted polarity is 0x10.
- R10: While control bit 6 (lock) is 1, writes to period, duty and polarity do not change the waveform.
- R11: Clearing the lock in the same control write that changes polarity makes the staged period, duty and polarity take effect together on the first cycle of the next period.
- R12: With the lock clear, a period or duty change made while running takes effect at the next wrap and not part-way through a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest case to reach is a commit with several changes pending at once. To get there, the channel runs with a lock held and with new period and duty values staged. The lock is then cleared together with a polarity flip while the count is part-way through a period. The stimulus does this after letting the locked channel run several periods. The bench then records the largest count seen before and after the next boundary, and this shows that the old period finishes intact and the new one starts whole. A behavioural model compares the output and the live count every cycle, so a commit that arrives early or late, or only in part, shows up on the cycle where it happens.

// File: rtl/pwm_ls_pkg.sv
package pwm_ls_pkg;
  localparam int CB_EN     = 0;
  localparam int CB_CONT   = 1;
  localparam int CB_ACTHI  = 3;
  localparam int CB_IDLEHI = 4;
  localparam int CB_ALIGN  = 5;
  localparam int CB_LOCK   = 6;
  localparam int CB_LP     = 8;
  localparam int CTRL_W    = 9;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 9'h17B;

  localparam logic [3:0] OFS_COUNT  = 4'h0;
  localparam logic [3:0] OFS_PERIOD = 4'h4;
  localparam logic [3:0] OFS_DUTY   = 4'h8;
  localparam logic [3:0] OFS_CTRL   = 4'hC;

  function automatic logic chan_running(input logic [CTRL_W-1:0] c);
    return c[CB_EN] & c[CB_CONT] & ~c[CB_ALIGN] & ~c[CB_LP];
  endfunction

  function automatic logic chan_locked(input logic [CTRL_W-1:0] c);
    return c[CB_LOCK];
  endfunction
endpackage

// File: rtl/pwm_ls_regbank.sv
module pwm_ls_regbank
  import pwm_ls_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     live_cnt,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     stg_period,
  output logic [DW-1:0]     stg_duty,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_period <= '0;
      stg_duty   <= '0;
      ctrl_q     <= '0;
    end else if (wr) begin
      case (addr)
        OFS_PERIOD: stg_period <= wdata;
        OFS_DUTY:   stg_duty   <= wdata;
        OFS_CTRL:   ctrl_q     <= wdata[CTRL_W-1:0] & CTRL_MASK;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_COUNT:  rdata = live_cnt;
      OFS_PERIOD: rdata = stg_period;
      OFS_DUTY:   rdata = stg_duty;
      OFS_CTRL:   rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_ls_shadow.sv
module pwm_ls_shadow #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] stg_period,
  input  logic [DW-1:0] stg_duty,
  input  logic          stg_hi,
  input  logic          stg_lo,
  output logic [DW-1:0] act_period,
  output logic [DW-1:0] act_duty,
  output logic          act_hi,
  output logic          act_lo
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_period <= '0;
      act_duty   <= '0;
      act_hi     <= 1'b0;
      act_lo     <= 1'b0;
    end else if (load) begin
      act_period <= stg_period;
      act_duty   <= stg_duty;
      act_hi     <= stg_hi;
      act_lo     <= stg_lo;
    end
  end
endmodule

// File: rtl/pwm_ls_counter.sv
module pwm_ls_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] period,
  output logic [DW-1:0] cnt,
  output logic          wrap
);
  localparam int XW = DW + 1;

  function automatic logic at_last(input logic [DW-1:0] c, input logic [DW-1:0] p);
    logic [XW-1:0] nxt;
    nxt = {1'b0, c} + XW'(1);
    return nxt >= {1'b0, p};
  endfunction

  assign wrap = run && at_last(cnt, period);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run||wrap) cnt <= '0;
    else                 cnt <= cnt + DW'(1);
  end
endmodule

// File: rtl/pwm_lockshadow.sv
module pwm_lockshadow
  import pwm_ls_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          pwm_out
);
  logic [DW-1:0]     stg_period, stg_duty, act_period, act_duty, cnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              act_hi, act_lo;
  logic              run_w, lock_w, wrap_w, commit_w;

  function automatic logic phase_level(input logic [DW-1:0] c, input logic [DW-1:0] d,
                                       input logic hi, input logic lo);
    return (c < d) ? hi : lo;
  endfunction

  assign run_w    = chan_running(ctrl_q);
  assign lock_w   = chan_locked(ctrl_q);
  assign commit_w = (!run_w || wrap_w) && !lock_w;

  pwm_ls_regbank #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .live_cnt(cnt_q), .rdata(reg_rdata), .stg_period(stg_period),
    .stg_duty(stg_duty), .ctrl_q(ctrl_q)
  );

  pwm_ls_shadow #(.DW(DW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(commit_w),
    .stg_period(stg_period), .stg_duty(stg_duty),
    .stg_hi(ctrl_q[CB_ACTHI]), .stg_lo(ctrl_q[CB_IDLEHI]),
    .act_period(act_period), .act_duty(act_duty), .act_hi(act_hi), .act_lo(act_lo)
  );

  pwm_ls_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_w), .period(act_period),
    .cnt(cnt_q), .wrap(wrap_w)
  );

  assign pwm_out = run_w ? phase_level(cnt_q, act_duty, act_hi, act_lo) : act_lo;
endmodule

// File: rtl/pwm_lockshadow_chk.sv
module pwm_lockshadow_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_w,
  input logic          lock_w,
  input logic          wrap_w,
  input logic [DW-1:0] cnt_q,
  input logic [DW-1:0] act_period,
  input logic [DW-1:0] act_duty,
  input logic          act_hi,
  input logic          act_lo,
  input logic          pwm_out
);
  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |=> cnt_q == '0); // R5
  AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_w |=> cnt_q == '0); // R6
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && act_period != '0) |-> cnt_q < act_period); // R6
  AST_FULL_DUTY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && act_period != '0 && act_duty >= act_period) |-> pwm_out == act_hi); // R8
  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_w) |-> ($stable(act_period) && $stable(act_duty) &&
                       $stable(act_hi) && $stable(act_lo))); // R10
  AST_COMMIT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(act_period) && $stable(act_duty)) |-> $past(wrap_w || !run_w)); // R12
endmodule

bind pwm_lockshadow pwm_lockshadow_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_w(run_w), .lock_w(lock_w), .wrap_w(wrap_w),
  .cnt_q(cnt_q), .act_period(act_period), .act_duty(act_duty),
  .act_hi(act_hi), .act_lo(act_lo), .pwm_out(pwm_out)
);

// File: tb/pwm_lockshadow_bench.sv
module pwm_lockshadow_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string phase = "R1";
  int unsigned max_seen = 0;

  // behavioural reference state
  longint m_sp = 0, m_sd = 0, m_ap = 0, m_ad = 0, m_cnt = 0;
  int     m_ctrl = 0;
  bit     m_hi = 0, m_lo = 0;

  always #10 clk = ~clk;

  pwm_lockshadow u_pwm_lockshadow (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit m_running();
    return (m_ctrl & 1) != 0 && (m_ctrl & 2) != 0 && (m_ctrl & 32) == 0 && (m_ctrl & 256) == 0;
  endfunction

  function automatic bit m_level();
    if (!m_running()) return m_lo;
    return (m_cnt < m_ad) ? m_hi : m_lo;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sp = 0; m_sd = 0; m_ap = 0; m_ad = 0; m_cnt = 0; m_ctrl = 0; m_hi = 0; m_lo = 0;
    end else begin
      bit take;
      take = 0;
      if (!m_running()) m_cnt = 0;
      else if (m_cnt + 1 >= m_ap) begin m_cnt = 0; take = 1; end
      else m_cnt = m_cnt + 1;
      if ((!m_running() || take) && (m_ctrl & 64) == 0) begin
        m_ap = m_sp; m_ad = m_sd;
        m_hi = (m_ctrl >> 3) & 1; m_lo = (m_ctrl >> 4) & 1;
      end
      if (reg_wr) begin
        if (reg_addr == 4'h4) m_sp = reg_wdata;
        else if (reg_addr == 4'h8) m_sd = reg_wdata;
        else if (reg_addr == 4'hC) m_ctrl = int'(reg_wdata & 32'h17B);
      end
    end
    #5;
    if (rst_n && !finished) begin
      check({phase, " waveform"}, pwm_out, m_level());
      if (reg_addr == 4'h0 && !reg_wr) begin
        check({phase, " live count"}, reg_rdata, m_cnt);
        if (reg_rdata > max_seen) max_seen = reg_rdata;
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 4'h0; reg_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
    reg_addr = 4'h0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    phase = "R1";
    rd(4'h0, v); check("R1 count", v, 0);
    rd(4'h4, v); check("R1 period", v, 0);
    rd(4'h8, v); check("R1 duty", v, 0);
    rd(4'hC, v); check("R1 ctrl", v, 0);
    check("R1 output", pwm_out, 0);
    // R2: control mask and unmapped offset
    phase = "R2";
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v); check("R2 ctrl mask", v, 32'h17B);
    rd(4'h2, v); check("R2 unmapped", v, 0);
    wr(4'hC, 32'h0);
    wr(4'h4, 32'd10); wr(4'h8, 32'd3);
    rd(4'h4, v); check("R2 period readback", v, 10);
    rd(4'h8, v); check("R2 duty readback", v, 3);
    // R6/R7: normal polarity, running
    phase = "R7";
    wr(4'hC, 32'h0B);
    max_seen = 0; idle(25);
    check("R6 max count", max_seen, 9);
    // R3: count writes ignored
    phase = "R3";
    wr(4'h0, 32'd5);
    idle(4);
    // R4: each blocking field
    phase = "R4";
    wr(4'hC, 32'h09); idle(3); rd(4'h0, v); check("R4 no continuous", v, 0);
    wr(4'hC, 32'h2B); idle(3); rd(4'h0, v); check("R4 right align", v, 0);
    wr(4'hC, 32'h10B); idle(3); rd(4'h0, v); check("R4 low power", v, 0);
    // R9/R5: inverted polarity
    phase = "R9";
    wr(4'hC, 32'h13); idle(23);
    phase = "R5";
    wr(4'hC, 32'h12); idle(3);
    check("R5 idle inverted level", pwm_out, 1);
    // R8: duty extremes
    phase = "R8";
    wr(4'h8, 32'd0); wr(4'hC, 32'h0B); idle(22);
    wr(4'h8, 32'd20); idle(22);
    check("R8 full duty level", pwm_out, 1);
    wr(4'h8, 32'd3); wr(4'h4, 32'd1); idle(6);
    wr(4'h4, 32'd10); idle(12);
    // R10: locked staging
    phase = "R10";
    wr(4'hC, 32'h4B);
    wr(4'h4, 32'd6); wr(4'h8, 32'd2);
    max_seen = 0; idle(30);
    check("R10 old period kept", max_seen, 9);
    rd(4'h4, v); check("R10 staged readback", v, 6);
    // R11: unlock with polarity flip mid-period
    phase = "R11";
    idle(4);
    wr(4'hC, 32'h13);
    idle(12);
    max_seen = 0; idle(20);
    check("R11 new period active", max_seen, 5);
    // R12: unlocked mid-period changes
    phase = "R12";
    idle(2);
    wr(4'h8, 32'd4);
    idle(3);
    wr(4'h4, 32'd8);
    max_seen = 0; idle(3);
    check("R12 old period still running", (max_seen <= 5) ? 1 : 0, 1);
    idle(8); max_seen = 0; idle(20);
    check("R12 new period", max_seen, 7);
    finish_run();
  end
endmodule